// File: doc/BRIEF.md
# Column Variance Peak Decision Unit

This unit takes the scalogram elements of one column, one element per enabled clock, and decides whether the sample at the column's centre is a peak. Each element is a small unsigned fixed-point marker. In an upstream scalogram stage, a scale at which the sample is a local maximum yields zero. Any other scale yields a value between one and two. A column whose markers barely spread is a peak candidate, so the unit measures the spread of the column and compares it with a programmable limit.

The spread is a variance, and no square root is taken. The column length L is fixed at build time, so the unit avoids a general divider. It forms L times the sum of squares, minus the square of the sum. That quantity is L² times the variance. It is checked against the threshold times L². The running sum and running square sum update on every accepted element. The result registers one enabled clock after the element marked last, together with a one-cycle done strobe.

A clock enable gates the whole unit, so the unit can run at the sample rate of a slower front end.

Top module: `col_var_peak`

## Requirements
- R1: After a synchronous active-high reset, done, peak_flag and var_scaled are all zero.
- R2: An accepted element marked first restarts both accumulations, so nothing from the previous column contributes to the next result.
- R3: var_scaled equals L·Σz² − (Σz)² over the elements accepted from the first-marked element to the last-marked element inclusive.
- R4: peak_flag is 1 exactly when var_scaled ≤ thresh·L². thresh is sampled on the enabled edge that registers the result.
- R5: A column of all-zero elements gives var_scaled = 0 and peak_flag = 1, including when thresh is 0.
- R6: With thresh = 0, a column that mixes zero and nonzero elements gives peak_flag = 0.
- R7: done is 1 for exactly one enabled cycle, starting one enabled edge after the edge that accepts the last-marked element. peak_flag and var_scaled hold their values until the next result.
- R8: While ce is 0, no element is accepted, and done, peak_flag and var_scaled do not change.
- R9: Cycles with elem_valid = 0 and ce = 1 add nothing to the accumulation.
- R10: Full-scale elements (511 for the default 9-bit width) do not overflow. An all-511 column gives var_scaled = 0, and an alternating 0/511 column gives its exact value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable for the whole unit |
| elem_valid | input | 1 | An element is present on elem_data |
| elem_first | input | 1 | The element opens a column |
| elem_last | input | 1 | The element closes a column |
| elem_data | input | ELEM_W | Unsigned fixed-point scalogram element |
| thresh | input | THR_W | Variance limit, in the units of z² |
| done | output | 1 | Result strobe |
| peak_flag | output | 1 | The column is judged a peak |
| var_scaled | output | NUM_W | L² times the column variance |

## Verification
The assertions assume that every column is framed correctly: it opens with a first-marked element and ends with a last-marked element, with exactly L accepted elements in between. They also assume that thresh is steady while a result registers. The bench builds every column from exactly L elements and marks only the first and last of them. Inside a column it inserts idle cycles and disabled cycles carrying junk framing. It changes thresh only between columns, before the first element is driven.

// File: rtl/col_var_pkg.sv
package col_var_pkg;

  // bits needed to hold the value n
  function automatic int cnt_bits(input int n);
    return $clog2(n + 1);
  endfunction

  // larger of two widths
  function automatic int max_w(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/col_accum.sv
module col_accum #(
  parameter int ELEM_W = 9,
  parameter int SUM_W  = 15,
  parameter int SQ_W   = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              valid,
  input  logic              first,
  input  logic              last,
  input  logic [ELEM_W-1:0] data,
  output logic [SUM_W-1:0]  sum,
  output logic [SQ_W-1:0]   sqsum,
  output logic              fin
);

  logic [SQ_W-1:0]  sq_term;
  logic [SUM_W-1:0] sum_base;
  logic [SQ_W-1:0]  sq_base;

  always_comb begin
    sq_term  = SQ_W'(data) * SQ_W'(data);
    sum_base = first ? '0 : sum;
    sq_base  = first ? '0 : sqsum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum   <= '0;
      sqsum <= '0;
      fin   <= 1'b0;
    end else if (ce) begin
      fin <= valid & last;
      if (valid) begin
        sum   <= sum_base + SUM_W'(data);
        sqsum <= sq_base + sq_term;
      end
    end
  end

endmodule

// File: rtl/var_judge.sv
module var_judge #(
  parameter int L      = 33,
  parameter int SUM_W  = 15,
  parameter int SQ_W   = 24,
  parameter int THR_W  = 16,
  parameter int NUM_W  = 30,
  parameter int LIM_W  = 28
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             fin,
  input  logic [SUM_W-1:0] sum,
  input  logic [SQ_W-1:0]  sqsum,
  input  logic [THR_W-1:0] thresh,
  output logic             done,
  output logic             peak,
  output logic [NUM_W-1:0] var_scaled
);

  import col_var_pkg::*;

  localparam int CMP_W = max_w(NUM_W, LIM_W);

  logic [NUM_W-1:0] l_sq;
  logic [NUM_W-1:0] s_sq;
  logic [NUM_W-1:0] num;
  logic [LIM_W-1:0] lim;
  logic             under;

  always_comb begin
    l_sq  = NUM_W'(L) * NUM_W'(sqsum);
    s_sq  = NUM_W'(sum) * NUM_W'(sum);
    num   = l_sq - s_sq;
    lim   = LIM_W'(thresh) * LIM_W'(L * L);
    under = CMP_W'(num) <= CMP_W'(lim);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      peak       <= 1'b0;
      var_scaled <= '0;
    end else if (ce) begin
      done <= fin;
      if (fin) begin
        var_scaled <= num;
        peak       <= under;
      end
    end
  end

endmodule

// File: rtl/col_var_peak.sv
module col_var_peak
  import col_var_pkg::*;
#(
  parameter int L      = 33,
  parameter int ELEM_W = 9,
  parameter int THR_W  = 16,
  localparam int LW    = cnt_bits(L),
  localparam int NUM_W = 2 * ELEM_W + 2 * LW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              elem_valid,
  input  logic              elem_first,
  input  logic              elem_last,
  input  logic [ELEM_W-1:0] elem_data,
  input  logic [THR_W-1:0]  thresh,
  output logic              done,
  output logic              peak_flag,
  output logic [NUM_W-1:0]  var_scaled
);

  localparam int SUM_W = ELEM_W + LW;
  localparam int SQ_W  = 2 * ELEM_W + LW;
  localparam int LIM_W = THR_W + 2 * LW;

  logic [SUM_W-1:0] acc_sum;
  logic [SQ_W-1:0]  acc_sq;
  logic             acc_fin;

  col_accum #(
    .ELEM_W(ELEM_W),
    .SUM_W (SUM_W),
    .SQ_W  (SQ_W)
  ) u_accum (
    .clk  (clk),
    .rst  (rst),
    .ce   (ce),
    .valid(elem_valid),
    .first(elem_first),
    .last (elem_last),
    .data (elem_data),
    .sum  (acc_sum),
    .sqsum(acc_sq),
    .fin  (acc_fin)
  );

  var_judge #(
    .L    (L),
    .SUM_W(SUM_W),
    .SQ_W (SQ_W),
    .THR_W(THR_W),
    .NUM_W(NUM_W),
    .LIM_W(LIM_W)
  ) u_judge (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .fin       (acc_fin),
    .sum       (acc_sum),
    .sqsum     (acc_sq),
    .thresh    (thresh),
    .done      (done),
    .peak      (peak_flag),
    .var_scaled(var_scaled)
  );

endmodule

// File: rtl/col_var_peak_chk.sv
module col_var_peak_chk #(
  parameter int THR_W = 16,
  parameter int NUM_W = 30
) (
  input logic             clk,
  input logic             rst,
  input logic             ce,
  input logic             elem_valid,
  input logic             elem_last,
  input logic [THR_W-1:0] thresh,
  input logic             done,
  input logic             peak_flag,
  input logic [NUM_W-1:0] var_scaled
);

  // R5
  zero_var_peak_chk: assert property (@(posedge clk) disable iff (rst)
    (done && var_scaled == '0) |-> peak_flag);

  // R6
  zero_thr_strict_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && $past(thresh) == '0) |-> (!peak_flag || var_scaled == '0));

  // R7
  done_timing_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(done) && $past(ce) && $past(ce, 2)) |-> $past(elem_valid && elem_last, 2));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    (done && ce) |=> (!done || $past(elem_valid && elem_last && ce, 2)));

  // R8
  ce_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(done) && $stable(peak_flag) && $stable(var_scaled)));

endmodule

bind col_var_peak col_var_peak_chk #(
  .THR_W(THR_W),
  .NUM_W(NUM_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ce        (ce),
  .elem_valid(elem_valid),
  .elem_last (elem_last),
  .thresh    (thresh),
  .done      (done),
  .peak_flag (peak_flag),
  .var_scaled(var_scaled)
);

// File: tb/col_var_peak_test.sv
module col_var_peak_test;

  localparam int CLK_PERIOD = 10;
  localparam int L      = 33;
  localparam int ELEM_W = 9;
  localparam int THR_W  = 16;
  localparam int NUM_W  = 2 * ELEM_W + 2 * $clog2(L + 1);

  logic              clk = 1'b0;
  logic              rst, ce, elem_valid, elem_first, elem_last;
  logic [ELEM_W-1:0] elem_data;
  logic [THR_W-1:0]  thresh;
  logic              done, peak_flag;
  logic [NUM_W-1:0]  var_scaled;

  int n_chk  = 0;
  int n_fail = 0;
  int col [L];

  always #(CLK_PERIOD / 2) clk = ~clk;

  col_var_peak #(.L(L), .ELEM_W(ELEM_W), .THR_W(THR_W)) uut (
    .clk(clk), .rst(rst), .ce(ce), .elem_valid(elem_valid),
    .elem_first(elem_first), .elem_last(elem_last), .elem_data(elem_data),
    .thresh(thresh), .done(done), .peak_flag(peak_flag), .var_scaled(var_scaled)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_var();
    longint s = 0;
    longint q = 0;
    for (int i = 0; i < L; i++) begin
      s += col[i];
      q += longint'(col[i]) * col[i];
    end
    return L * q - s * s;
  endfunction

  // Drive one column, with optional idle and disabled cycles (R8, R9)
  task automatic run_col(input int thr, input int gap_pct, input int ce_pct,
                         input bit freeze, input string req);
    longint ev = exp_var();
    bit     ep = (ev <= longint'(thr) * L * L);
    thresh = THR_W'(thr);
    for (int i = 0; i < L; i++) begin
      while (int'($urandom % 100) < gap_pct) begin
        @(negedge clk);
        ce = 1'b1; elem_valid = 1'b0; elem_first = 1'b1; elem_last = 1'b1;
        elem_data = ELEM_W'($urandom);
      end
      while (int'($urandom % 100) < ce_pct) begin
        @(negedge clk);
        ce = 1'b0; elem_valid = 1'b1; elem_first = 1'($urandom);
        elem_last = 1'($urandom); elem_data = ELEM_W'($urandom);
      end
      @(negedge clk);
      if (i > 0) chk(done == 1'b0, "R7 no done mid-column", done, 0);
      ce = 1'b1; elem_valid = 1'b1; elem_first = (i == 0);
      elem_last = (i == L - 1); elem_data = ELEM_W'(col[i]);
    end
    @(negedge clk);
    elem_valid = 1'b0; elem_first = 1'b0; elem_last = 1'b0;
    @(negedge clk);
    chk(done == 1'b1, {req, " R7 done"}, done, 1);
    chk(longint'(var_scaled) == ev, {req, " R3 var"}, var_scaled, ev);
    chk(peak_flag == ep, {req, " R4 peak"}, peak_flag, ep);
    if (freeze) begin
      ce = 1'b0; elem_valid = 1'b1; elem_first = 1'b1; elem_last = 1'b1;
      elem_data = '1;
      repeat (3) @(negedge clk);
      chk(done == 1'b1, "R8 done frozen", done, 1);
      chk(longint'(var_scaled) == ev, "R8 var frozen", var_scaled, ev);
      ce = 1'b1; elem_valid = 1'b0; elem_first = 1'b0; elem_last = 1'b0;
    end
    @(negedge clk);
    chk(done == 1'b0, {req, " R7 single strobe"}, done, 0);
    chk(longint'(var_scaled) == ev, {req, " R7 hold"}, var_scaled, ev);
  endtask

  initial begin
    longint v;
    void'($urandom(32'd20250611));
    rst = 1'b1; ce = 1'b1; elem_valid = 1'b1; elem_first = 1'b1;
    elem_last = 1'b1; elem_data = '1; thresh = '1;
    repeat (4) @(negedge clk);
    elem_valid = 1'b0; elem_first = 1'b0; elem_last = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    // R1
    chk(done == 1'b0, "R1 done", done, 0);
    chk(peak_flag == 1'b0, "R1 peak", peak_flag, 0);
    chk(var_scaled == '0, "R1 var", var_scaled, 0);

    // R5 all zero, threshold zero
    foreach (col[i]) col[i] = 0;
    run_col(0, 0, 0, 0, "R5 zeros");
    chk(peak_flag == 1'b1, "R5 zero column peak", peak_flag, 1);

    // R10 full scale flat, then alternating
    foreach (col[i]) col[i] = 511;
    run_col(0, 0, 0, 0, "R10 flat");
    chk(var_scaled == '0, "R10 flat var zero", var_scaled, 0);
    foreach (col[i]) col[i] = (i % 2) ? 511 : 0;
    run_col(0, 10, 0, 0, "R10 alternating");
    chk(peak_flag == 1'b0, "R6 alternating not peak", peak_flag, 0);

    // R2 small column right after a big one
    foreach (col[i]) col[i] = (i == 16) ? 0 : 256;
    run_col(0, 0, 0, 0, "R2 restart");
    chk(peak_flag == 1'b0, "R6 single zero marker", peak_flag, 0);

    // R4 threshold boundary
    foreach (col[i]) col[i] = (i == 0) ? 256 : 0;
    v = exp_var();
    run_col(int'(v / (L * L)), 0, 0, 0, "R4 below limit");
    chk(peak_flag == 1'b0, "R4 just over threshold", peak_flag, 0);
    run_col(int'(v / (L * L)) + 1, 0, 0, 0, "R4 above limit");
    chk(peak_flag == 1'b1, "R4 just under threshold", peak_flag, 1);

    // R8 / R9 stalls and freeze
    foreach (col[i]) col[i] = int'($urandom % 2) * (256 + int'($urandom % 256));
    run_col(0, 30, 30, 1, "R8 R9 stalls");

    // Random columns of zero-or-(1..2) markers
    for (int n = 0; n < 60; n++) begin
      int zp = int'($urandom % 100);
      foreach (col[i]) col[i] = (int'($urandom % 100) < zp) ? 0 : 256 + int'($urandom % 256);
      run_col((n % 2) ? int'($urandom % 40000) : 0, int'($urandom % 20),
              int'($urandom % 20), (n % 7) == 0, "R3 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule